// File: doc/BRIEF.md
# First-Hit Real-Time Address Encoder

This block watches 64 channel hit lines and reports the address of the earliest channel to fire during an acquisition. Each channel drives two strobes: one raised when its signal crosses threshold and one raised when its peak is found. A mode input picks which of the two counts as a hit. The block latches the first qualifying hit, raises a fast event flag and presents the 6-bit channel number. It then ignores all further activity until it is re-armed.

The model is synchronous on a fast sampling clock. All strobes seen in one sampling cycle form a single coincidence window, and inside that window the lowest channel number wins. Masked channels take no part. A global enable and the acquisition-mode input gate the whole function. An optional self-reset drops the flag after a fixed number of cycles, which is 40 by default (40 ns at a 1 GHz sampling rate), and re-arms the capture. An acquisition reset pulse re-arms it at any time.

The control is a three-state machine:
- `ST_IDLE`: the function is off.
- `ST_ARMED`: the block is waiting for a hit.
- `ST_CAPTURED`: the flag is high and the address is held.

Its transitions are:
- *arm* (IDLE→ARMED) when acquisition mode and enable are both high.
- *capture* (ARMED→CAPTURED) on any unmasked selected hit while no acquisition reset is present.
- *rearm* (CAPTURED→ARMED) on an acquisition reset or when the self-reset expires.
- *disarm* (ARMED or CAPTURED→IDLE) when acquisition mode or enable goes low.

Top module: `first_hit_encoder`

## Requirements
- R1: After reset, and in every cycle in which `event_flag` is 0, `event_addr` reads 0.
- R2: An unmasked selected hit seen at a clock edge while armed sets `event_flag` at that edge, and `event_addr` then gives the hit's channel number as an unsigned binary index (channel 0 = 0, channel 63 = 63).
- R3: When several unmasked selected hits are present in the same cycle, the lowest channel number is reported.
- R4: Once `event_flag` is set, hits in later cycles are ignored, even lower-numbered ones, and `event_addr` stays unchanged while the flag stays high.
- R5: With `trig_at_peak`=0 only `thr_strobe` bits count as hits; with `trig_at_peak`=1 only `peak_strobe` bits count; the other vector has no effect.
- R6: A channel whose `chan_mask` bit is 1 never wins; if all hitting channels are masked no flag is raised.
- R7: With `fh_enable` low no flag is raised, and dropping it clears a raised flag at the next edge.
- R8: With `acq_mode` low no flag is raised and a raised flag clears at the next edge; after `acq_mode` and `fh_enable` are both high, one edge is spent arming before hits are accepted.
- R9: With `self_rst_en`=1 the flag stays high for exactly `SELF_RST_CYCLES` clock cycles, then clears with the address, and the block accepts a new hit in the following cycle.
- R10: With `self_rst_en`=0 the flag holds indefinitely; a one-cycle `acq_rst` pulse clears it at the next edge and re-arms capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Global reset, active low |
| acq_mode | input | 1 | High while in acquisition mode |
| fh_enable | input | 1 | Enable for the first-hit function |
| acq_rst | input | 1 | Acquisition reset pulse; re-arms capture |
| trig_at_peak | input | 1 | Hit source: 0 = threshold strobe, 1 = peak strobe |
| self_rst_en | input | 1 | Enables the timed self-reset of the flag |
| chan_mask | input | 64 | Per-channel mask, 1 = channel excluded |
| thr_strobe | input | 64 | Per-channel threshold-crossing strobes |
| peak_strobe | input | 64 | Per-channel peak-found strobes |
| event_flag | output | 1 | Fast flag: a first hit has been latched |
| event_addr | output | 6 | Channel number of the first hit |

## Verification
The flag and the address come from registers. A hit driven between two edges therefore shows up just after the next rising edge, and the bench samples at the following falling edge. Clearing by `acq_rst`, by a dropped enable or by leaving acquisition follows the same one-edge rule. The self-reset window is measured by counting the consecutive falling-edge samples with the flag high, starting with the first sample after the capturing edge; the expected count is `SELF_RST_CYCLES`. Every table vector first re-arms with an `acq_rst` cycle, then applies one cycle of early hits and one cycle of late hits, and compares the outputs one edge after the late hits.

// File: rtl/fhe_pkg.sv
package fhe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_CAPTURED = 2'd2
    } fhe_state_e;

    function automatic int addr_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fhe_hit_select.sv
module fhe_hit_select #(
    parameter int NCH = 64
) (
    input  logic           peak_sel,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] thr,
    input  logic [NCH-1:0] pk,
    output logic [NCH-1:0] req
);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic src;
        assign src    = peak_sel ? pk[g] : thr[g];
        assign req[g] = src & ~mask[g];
    end

endmodule

// File: rtl/fhe_prio_enc.sv
module fhe_prio_enc #(
    parameter int NCH = 64,
    parameter int AW  = 6
) (
    input  logic [NCH-1:0] req,
    output logic           valid,
    output logic [AW-1:0]  idx
);

    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
    end

endmodule

// File: rtl/fhe_ctrl.sv
module fhe_ctrl
    import fhe_pkg::*;
#(
    parameter int AW              = 6,
    parameter int SELF_RST_CYCLES = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq_mode,
    input  logic          fh_enable,
    input  logic          acq_rst,
    input  logic          self_rst_en,
    input  logic          hit_valid,
    input  logic [AW-1:0] hit_idx,
    output logic          flag,
    output logic [AW-1:0] addr
);

    localparam int CW = (SELF_RST_CYCLES > 1) ? $clog2(SELF_RST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SELF_RST_CYCLES - 1);

    fhe_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [AW-1:0]  addr_q;
    logic           active;
    logic           expired;

    assign active  = acq_mode & fh_enable;
    assign expired = self_rst_en & (cnt_q == CNT_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (active) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!active)                   state_d = ST_IDLE;
                else if (!acq_rst && hit_valid) state_d = ST_CAPTURED;
            end
            ST_CAPTURED: begin
                if (!active)                 state_d = ST_IDLE;
                else if (acq_rst || expired) state_d = ST_ARMED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else begin
            if (state_q != ST_CAPTURED)          cnt_q <= '0;
            else if (self_rst_en && !expired)    cnt_q <= cnt_q + 1'b1;

            if (state_d != ST_CAPTURED)          addr_q <= '0;
            else if (state_q == ST_ARMED)        addr_q <= hit_idx;
        end
    end

    assign flag = (state_q == ST_CAPTURED);
    assign addr = addr_q;

endmodule

// File: rtl/first_hit_encoder.sv
module first_hit_encoder #(
    parameter int NCH             = 64,
    parameter int SELF_RST_CYCLES = 40,
    localparam int AW             = fhe_pkg::addr_w(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acq_mode,
    input  logic           fh_enable,
    input  logic           acq_rst,
    input  logic           trig_at_peak,
    input  logic           self_rst_en,
    input  logic [NCH-1:0] chan_mask,
    input  logic [NCH-1:0] thr_strobe,
    input  logic [NCH-1:0] peak_strobe,
    output logic           event_flag,
    output logic [AW-1:0]  event_addr
);

    logic [NCH-1:0] req;
    logic           hit_valid;
    logic [AW-1:0]  hit_idx;

    fhe_hit_select #(.NCH(NCH)) u_sel (
        .peak_sel (trig_at_peak),
        .mask     (chan_mask),
        .thr      (thr_strobe),
        .pk       (peak_strobe),
        .req      (req)
    );

    fhe_prio_enc #(.NCH(NCH), .AW(AW)) u_enc (
        .req   (req),
        .valid (hit_valid),
        .idx   (hit_idx)
    );

    fhe_ctrl #(.AW(AW), .SELF_RST_CYCLES(SELF_RST_CYCLES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .acq_mode    (acq_mode),
        .fh_enable   (fh_enable),
        .acq_rst     (acq_rst),
        .self_rst_en (self_rst_en),
        .hit_valid   (hit_valid),
        .hit_idx     (hit_idx),
        .flag        (event_flag),
        .addr        (event_addr)
    );

endmodule

// File: rtl/first_hit_encoder_chk.sv
module first_hit_encoder_chk #(
    parameter int NCH             = 64,
    parameter int SELF_RST_CYCLES = 40,
    parameter int AW              = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acq_mode,
    input  logic           fh_enable,
    input  logic           trig_at_peak,
    input  logic           self_rst_en,
    input  logic [NCH-1:0] chan_mask,
    input  logic [NCH-1:0] thr_strobe,
    input  logic [NCH-1:0] peak_strobe,
    input  logic           event_flag,
    input  logic [AW-1:0]  event_addr
);

    logic           past_valid;
    logic [NCH-1:0] src_q;
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] below;
    int             run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_valid <= 1'b0;
            src_q      <= '0;
            mask_q     <= '0;
            run_cnt    <= 0;
        end else begin
            past_valid <= 1'b1;
            src_q      <= trig_at_peak ? peak_strobe : thr_strobe;
            mask_q     <= chan_mask;
            run_cnt    <= (event_flag && self_rst_en) ? run_cnt + 1 : 0;
        end
    end

    assign below = ({{(NCH-1){1'b0}}, 1'b1} << event_addr) - 1'b1;

    assert_addr_zero_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !event_flag |-> event_addr == '0);

    assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && event_flag && $past(event_flag) |-> $stable(event_addr));

    assert_winner_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $rose(event_flag) |-> src_q[event_addr]);

    assert_winner_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $rose(event_flag) |-> (src_q & ~mask_q & below) == '0);

    assert_winner_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $rose(event_flag) |-> !mask_q[event_addr]);

    assert_no_flag_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && !$past(fh_enable) |-> !event_flag);

    assert_no_flag_outside_acq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && !$past(acq_mode) |-> !event_flag);

    assert_self_reset_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        event_flag |-> run_cnt < SELF_RST_CYCLES);

endmodule

bind first_hit_encoder first_hit_encoder_chk #(
    .NCH(NCH), .SELF_RST_CYCLES(SELF_RST_CYCLES), .AW(AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acq_mode     (acq_mode),
    .fh_enable    (fh_enable),
    .trig_at_peak (trig_at_peak),
    .self_rst_en  (self_rst_en),
    .chan_mask    (chan_mask),
    .thr_strobe   (thr_strobe),
    .peak_strobe  (peak_strobe),
    .event_flag   (event_flag),
    .event_addr   (event_addr)
);

// File: tb/test_first_hit_encoder.sv
module test_first_hit_encoder;

    localparam int NCH    = 64;
    localparam int SR_CYC = 40;
    localparam int AW     = 6;

    typedef struct packed {
        logic           peak;
        logic [NCH-1:0] mask;
        logic [NCH-1:0] a_thr;
        logic [NCH-1:0] a_pk;
        logic [NCH-1:0] b_thr;
        logic [NCH-1:0] b_pk;
        logic           exp_flag;
        logic [AW-1:0]  exp_addr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'h0, 64'h220, 64'h0, 64'h0, 64'h0, 1'b1, 6'd5},
        '{1'b0, 64'h0, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 64'h0, 1'b1, 6'd63},
        '{1'b1, 64'h0, 64'h4, 64'h100_0000_0000, 64'h0, 64'h0, 1'b1, 6'd40},
        '{1'b0, 64'h0, 64'h0, 64'h2, 64'h0, 64'h0, 1'b0, 6'd0},
        '{1'b0, 64'h8, 64'h10_0008, 64'h0, 64'h0, 64'h0, 1'b1, 6'd20},
        '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 64'h0, 1'b0, 6'd0},
        '{1'b0, 64'h0, 64'h4000_0000, 64'h0, 64'h10, 64'h0, 1'b1, 6'd30},
        '{1'b0, 64'h0, 64'h0, 64'h0, 64'h1, 64'h0, 1'b1, 6'd0},
        '{1'b1, 64'h800, 64'h0, 64'h0004_0000_0000_1800, 64'h0, 64'h0, 1'b1, 6'd12},
        '{1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 64'h0, 1'b1, 6'd0}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           acq_mode = 1'b0;
    logic           fh_enable = 1'b0;
    logic           acq_rst = 1'b0;
    logic           trig_at_peak = 1'b0;
    logic           self_rst_en = 1'b0;
    logic [NCH-1:0] chan_mask = '0;
    logic [NCH-1:0] thr_strobe = '0;
    logic [NCH-1:0] peak_strobe = '0;
    logic           event_flag;
    logic [AW-1:0]  event_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    first_hit_encoder #(.NCH(NCH), .SELF_RST_CYCLES(SR_CYC)) i_first_hit_encoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .acq_mode     (acq_mode),
        .fh_enable    (fh_enable),
        .acq_rst      (acq_rst),
        .trig_at_peak (trig_at_peak),
        .self_rst_en  (self_rst_en),
        .chan_mask    (chan_mask),
        .thr_strobe   (thr_strobe),
        .peak_strobe  (peak_strobe),
        .event_flag   (event_flag),
        .event_addr   (event_addr)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic outs(input string req, input int ef, input int ea);
        chk({req, " flag"}, int'(event_flag), ef);
        chk({req, " addr"}, int'(event_addr), ea);
    endtask

    task automatic rearm();
        acq_rst = 1'b1;
        tick();
        acq_rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int highs;
        tick();
        tick();
        outs("R1 reset", 0, 0);
        rst_n = 1'b1;
        acq_mode  = 1'b1;
        fh_enable = 1'b1;
        tick();

        // table: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            trig_at_peak = VECS[v].peak;
            chan_mask    = VECS[v].mask;
            rearm();
            thr_strobe  = VECS[v].a_thr;
            peak_strobe = VECS[v].a_pk;
            tick();
            thr_strobe  = VECS[v].b_thr;
            peak_strobe = VECS[v].b_pk;
            tick();
            thr_strobe  = '0;
            peak_strobe = '0;
            outs($sformatf("R2/R3/R5/R6 vec%0d", v), int'(VECS[v].exp_flag), int'(VECS[v].exp_addr));
        end
        trig_at_peak = 1'b0;
        chan_mask    = '0;

        // R4: lower index after capture is ignored, address held
        rearm();
        thr_strobe = 64'h4000_0000;
        tick();
        thr_strobe = 64'h1;
        for (int k = 0; k < 3; k++) begin
            tick();
            outs("R4 hold", 1, 30);
        end
        thr_strobe = '0;

        // R10: flag holds without self-reset, acq_rst clears
        for (int k = 0; k < 60; k++) tick();
        outs("R10 long hold", 1, 30);
        rearm();
        outs("R10 acq_rst clear", 0, 0);

        // R9: self-reset window length and rearm
        self_rst_en = 1'b1;
        thr_strobe = 64'h80;
        tick();
        thr_strobe = '0;
        outs("R9 captured", 1, 7);
        highs = 0;
        for (int k = 0; k < 3 * SR_CYC; k++) begin
            if (!event_flag) break;
            highs++;
            tick();
        end
        chk("R9 window cycles", highs, SR_CYC);
        outs("R9 cleared", 0, 0);
        thr_strobe = 64'h200;
        tick();
        thr_strobe = '0;
        outs("R9 rearmed", 1, 9);
        self_rst_en = 1'b0;

        // R7: enable off clears and blocks; re-enable needs arming edge
        fh_enable = 1'b0;
        tick();
        outs("R7 disable clears", 0, 0);
        thr_strobe = 64'h400;
        tick();
        outs("R7 disabled ignores hit", 0, 0);
        fh_enable = 1'b1;
        tick();
        outs("R8 arming edge", 0, 0);
        tick();
        outs("R7 re-enabled capture", 1, 10);

        // R8: leaving acquisition clears and blocks
        acq_mode = 1'b0;
        tick();
        outs("R8 leave acq clears", 0, 0);
        tick();
        outs("R8 no acq ignores hit", 0, 0);
        thr_strobe = '0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule